// File: doc/BRIEF.md
# Aliased Byte/Word Write Buffer FIFO

This block is the write-side data buffer of a host-facing storage controller. A microprocessor pushes sector data through a window of byte addresses. Every address in that window feeds the same 16-entry, 16-bit FIFO, so a host can burst across consecutive addresses without changing its target. In word mode each write stores a complete 16-bit word. In byte mode, a write to an even address holds the low byte. The write to the following odd address supplies the high byte and commits the assembled word.

A downstream sector engine drains the buffer one word at a time through a valid/ready handshake. The host sees three status outputs: a ready flag that tells it when a fresh 32-byte block may begin, a 5-bit fill count, and a sticky overflow flag for writes that found the buffer full.

Top module: `wbuf_alias_fifo`

## Requirements
- R1: A host write whose byte address lies outside 0x40..0x7F changes neither the stored words nor the fill count.
- R2: With `host_word_mode` = 1, a write to any address in 0x40..0x7F stores all 16 bits of `host_data` as one FIFO entry. The fill count rises by one on the next cycle.
- R3: With `host_word_mode` = 0, a write to an even in-window address (bit 0 = 0) latches `host_data[7:0]` as a pending low byte. It leaves the fill count unchanged.
- R4: With `host_word_mode` = 0, a write to an odd in-window address (bit 0 = 1) stores the word {`host_data[7:0]`, pending low byte}, with the new byte in bits 15:8. It then clears the pending byte to 0x00. A word-mode write also clears the pending byte.
- R5: The FIFO holds up to 16 words. `out_data` presents the oldest stored word, and `out_valid` is 1 exactly when the fill count is non-zero.
- R6: A word leaves the FIFO on a cycle where `out_valid` and `out_ready` are both 1. The fill count then drops by one, or stays the same if a write is stored in that same cycle.
- R7: A write that would store a word while the fill count is 16 is dropped, even when a pop happens in that same cycle. It sets `ovf_flag`, which stays set until it is cleared.
- R8: `ovf_clr` = 1 clears `ovf_flag` on the next cycle, unless a dropped write occurs in that same cycle, in which case the flag stays set.
- R9: `host_ready` goes to 0 on the cycle after any in-window write. It returns to 1 one cycle after the fill count is 0 with no pending byte and no in-window write.
- R10: `fill_count` reports the number of stored words, 0 to 16.
- R11: A synchronous active-high `rst` empties the FIFO, discards the pending byte, clears `ovf_flag` and sets `host_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_data | input | 16 | Host write data; bits 7:0 used in byte mode |
| host_word_mode | input | 1 | 1 = word writes, 0 = byte writes |
| host_ready | output | 1 | Buffer empty, a new block may start |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky: a write was dropped while full |
| out_data | output | 16 | Oldest stored word |
| out_valid | output | 1 | A word is available |
| out_ready | input | 1 | Consumer accepts the word |
| fill_count | output | 5 | Number of stored words |

## Verification
The hardest state to reach from the ports is a full buffer that receives a write in the same cycle the consumer pops. The write must still be dropped while the count falls to 15. The bench first loads sixteen word writes with the consumer held off. It then drives one write together with `out_ready` and checks the new count, the next oldest word and the overflow flag. A second hard case is a pending even byte that is lost across a reset. The bench reaches it by issuing an even write, pulsing reset, and then checking that the next odd write yields a zero low byte.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_WORD = 1'b1
    } wr_mode_e;

endpackage

// File: rtl/wbuf_decode.sv
module wbuf_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned WIN_BASE = 64,
    parameter int unsigned WIN_SPAN = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic              odd
);
    localparam logic [ADDR_W:0] LO_A = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] HI_A = (ADDR_W+1)'(WIN_BASE + WIN_SPAN - 1);

    logic [ADDR_W:0] addr_x;

    always_comb begin
        addr_x = {1'b0, addr};
        in_win = (addr_x >= LO_A) && (addr_x <= HI_A);
        odd    = addr[0];
    end

endmodule

// File: rtl/wbuf_packer.sv
module wbuf_packer #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              word_mode,
    input  logic              odd,
    input  logic [DATA_W-1:0] wr_data,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              pend
);
    localparam int unsigned LANE_W = DATA_W / 2;

    typedef struct packed {
        logic [LANE_W-1:0] low;
        logic              pend;
    } pk_t;

    pk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        push_data = wr_data;
        if (wr_en) begin
            if (word_mode) begin
                push      = 1'b1;
                push_data = wr_data;
                st_d      = '0;
            end else if (odd) begin
                push      = 1'b1;
                push_data = {wr_data[LANE_W-1:0], st_q.low};
                st_d      = '0;
            end else begin
                st_d.low  = wr_data[LANE_W-1:0];
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         drop
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } ff_t;

    ff_t st_d, st_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok, full;

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        full    = (st_q.cnt == FULL_C);
        push_ok = push && !full;
        pop_ok  = pop && (st_q.cnt != '0);
        drop    = push && full;
        if (push_ok) begin
            mem_d[st_q.wr_ptr] = push_data;
            st_d.wr_ptr = (st_q.wr_ptr == LAST_P) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_P) ? '0 : st_q.rd_ptr + 1'b1;
        end
        if (push_ok && !pop_ok) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_ok && !push_ok) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data  = mem_q[st_q.rd_ptr];
    assign rd_valid = (st_q.cnt != '0);
    assign count    = st_q.cnt;

endmodule

// File: rtl/wbuf_alias_fifo.sv
module wbuf_alias_fifo #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned WIN_BASE = 64,
    parameter int unsigned WIN_SPAN = 64,
    localparam int unsigned CNT_W   = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_word_mode,
    output logic              host_ready,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CNT_W-1:0]  fill_count
);
    import wbuf_pkg::*;

    typedef struct packed {
        logic ready;
        logic ovf;
    } stat_t;

    stat_t st_d, st_q;
    wr_mode_e mode;
    logic in_win, odd, accepted;
    logic push, pend, drop;
    logic [DATA_W-1:0] push_data;
    logic [CNT_W-1:0] cnt;

    assign mode     = wr_mode_e'(host_word_mode);
    assign accepted = host_wr && in_win;

    wbuf_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_SPAN(WIN_SPAN)
    ) u_decode (
        .addr  (host_addr),
        .in_win(in_win),
        .odd   (odd)
    );

    wbuf_packer #(
        .DATA_W(DATA_W)
    ) u_packer (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accepted),
        .word_mode(mode == MODE_WORD),
        .odd      (odd),
        .wr_data  (host_data),
        .push     (push),
        .push_data(push_data),
        .pend     (pend)
    );

    wbuf_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_data(push_data),
        .pop      (out_ready),
        .rd_data  (out_data),
        .rd_valid (out_valid),
        .count    (cnt),
        .drop     (drop)
    );

    always_comb begin
        st_d = st_q;
        if (accepted) begin
            st_d.ready = 1'b0;
        end else if ((cnt == '0) && !pend) begin
            st_d.ready = 1'b1;
        end
        if (drop) begin
            st_d.ovf = 1'b1;
        end else if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ready: 1'b1, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign host_ready = st_q.ready;
    assign ovf_flag   = st_q.ovf;
    assign fill_count = cnt;

endmodule

// File: rtl/wbuf_alias_fifo_chk.sv
module wbuf_alias_fifo_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned WIN_BASE = 64,
    parameter int unsigned WIN_SPAN = 64,
    parameter int unsigned CNT_W    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_word_mode,
    input logic              host_ready,
    input logic              ovf_clr,
    input logic              ovf_flag,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CNT_W-1:0]  fill_count
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam int unsigned HI_I = WIN_BASE + WIN_SPAN - 1;

    logic win;
    assign win = (int'(host_addr) >= int'(WIN_BASE)) && (int'(host_addr) <= int'(HI_I));

    p_cap_r10: assert property (@(posedge clk) disable iff (rst)
        fill_count <= FULL_C);

    p_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid == (fill_count != '0));

    p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
        host_wr && !win && !out_valid |=> $stable(fill_count));

    p_ready_r9: assert property (@(posedge clk) disable iff (rst)
        host_wr && win |=> !host_ready);

    p_pop_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !host_wr |=> fill_count == $past(fill_count) - 1'b1);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !ovf_clr |=> ovf_flag);

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_count == FULL_C) && host_wr && win && host_word_mode |=> ovf_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && ovf_clr && !host_wr |=> !ovf_flag);

endmodule

bind wbuf_alias_fifo wbuf_alias_fifo_chk #(
    .ADDR_W  (ADDR_W),
    .DEPTH   (DEPTH),
    .WIN_BASE(WIN_BASE),
    .WIN_SPAN(WIN_SPAN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_addr     (host_addr),
    .host_wr       (host_wr),
    .host_word_mode(host_word_mode),
    .host_ready    (host_ready),
    .ovf_clr       (ovf_clr),
    .ovf_flag      (ovf_flag),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .fill_count    (fill_count)
);

// File: tb/wbuf_alias_fifo_bench.sv
module wbuf_alias_fifo_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_data = '0;
    logic        host_word_mode = 1'b0;
    logic        host_ready;
    logic        ovf_clr = 1'b0;
    logic        ovf_flag;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [4:0]  fill_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wbuf_alias_fifo u_wbuf_alias_fifo (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_data(host_data), .host_word_mode(host_word_mode),
        .host_ready(host_ready), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .fill_count(fill_count)
    );

    // {word_mode, addr, data, expected fill after}
    localparam logic [29:0] VEC [8] = '{
        {1'b1, 8'h40, 16'h1111, 5'd1},   // R2
        {1'b1, 8'h7F, 16'h2222, 5'd2},   // R2 top of window
        {1'b1, 8'h80, 16'h3333, 5'd2},   // R1 above window
        {1'b0, 8'h42, 16'h00AB, 5'd2},   // R3 even byte held
        {1'b0, 8'h43, 16'h00CD, 5'd3},   // R4 odd byte commits
        {1'b1, 8'h3F, 16'h4444, 5'd3},   // R1 below window
        {1'b0, 8'h55, 16'h00EE, 5'd4},   // R4 odd with cleared holding
        {1'b1, 8'h66, 16'h5555, 5'd5}    // R2
    };
    localparam logic [15:0] EXP_POP [5] = '{16'h1111, 16'h2222, 16'hCDAB, 16'hEE00, 16'h5555};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; one clock edge passes; returns at next negedge
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [15:0] d,
                       input logic wm, input logic rdy, input logic clr);
        host_wr = wr; host_addr = a; host_data = d; host_word_mode = wm;
        out_ready = rdy; ovf_clr = clr;
        @(negedge clk);
        host_wr = 1'b0; out_ready = 1'b0; ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-R actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 ready", host_ready, 1);
        chk("R11 fill", fill_count, 0);
        chk("R11 valid", out_valid, 0);
        chk("R11 ovf", ovf_flag, 0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, VEC[i][28:21], VEC[i][20:5], VEC[i][29], 1'b0, 1'b0);
            chk("R1/R2/R3/R4/R10 fill", fill_count, int'(VEC[i][4:0]));
        end
        chk("R9 ready low after writes", host_ready, 0);
        chk("R5 valid", out_valid, 1);

        for (int i = 0; i < 5; i++) begin
            chk("R5 oldest word", out_data, EXP_POP[i]);
            cyc(1'b0, 8'h00, 16'h0, 1'b0, 1'b1, 1'b0);
            chk("R6 fill after pop", fill_count, 4 - i);
        end
        chk("R9 ready still low on empty cycle", host_ready, 0);
        @(negedge clk);
        chk("R9 ready reasserted", host_ready, 1);

        // fill to 16
        for (int i = 0; i < 16; i++) begin
            cyc(1'b1, 8'(8'h40 + i), 16'(16'h0100 + i), 1'b1, 1'b0, 1'b0);
        end
        chk("R10 full count", fill_count, 16);
        cyc(1'b1, 8'h41, 16'hDEAD, 1'b1, 1'b0, 1'b0);
        chk("R7 drop keeps count", fill_count, 16);
        chk("R7 ovf set", ovf_flag, 1);
        chk("R5 oldest after drop", out_data, 16'h0100);
        // write while full together with pop: write dropped
        cyc(1'b1, 8'h44, 16'hBEEF, 1'b1, 1'b1, 1'b0);
        chk("R7 full push+pop count", fill_count, 15);
        chk("R7 next oldest", out_data, 16'h0101);
        // push and pop at 15: count stays
        cyc(1'b1, 8'h45, 16'hCAFE, 1'b1, 1'b1, 1'b0);
        chk("R6 push+pop count", fill_count, 15);
        chk("R6 head advances", out_data, 16'h0102);
        chk("R7 ovf sticky", ovf_flag, 1);
        cyc(1'b0, 8'h00, 16'h0, 1'b0, 1'b0, 1'b1);
        chk("R8 ovf cleared", ovf_flag, 0);
        // drain, last word should be the one written at count 15
        for (int i = 0; i < 14; i++) cyc(1'b0, 8'h00, 16'h0, 1'b0, 1'b1, 1'b0);
        chk("R6 last word", out_data, 16'hCAFE);
        cyc(1'b0, 8'h00, 16'h0, 1'b0, 1'b1, 1'b0);
        chk("R6 drained", fill_count, 0);
        @(negedge clk);

        // pending byte keeps ready low
        cyc(1'b1, 8'h42, 16'h0077, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 pending byte holds ready low", host_ready, 0);
        chk("R3 no push", fill_count, 0);
        // reset drops pending byte
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 ready after reset", host_ready, 1);
        cyc(1'b1, 8'h43, 16'h0099, 1'b0, 1'b0, 1'b0);
        chk("R11 pending cleared", out_data, 16'h9900);
        chk("R4 fill", fill_count, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule